// File: doc/BRIEF.md
# Raster line buffer with serial video output

This block holds one raster line of print data and plays it out as a serial dot stream. A DMA engine fills it one byte at a time. The block asks for bytes through a request line and keeps asking while there is room and the current line still needs data. The laser side starts each line with a one-cycle start pulse, which also latches the line length in bits. After that, each pulse of a dot-clock enable moves one bit onto the video output, most significant bit of each byte first. A valid flag stays high while line bits are on the output.

Storage is 10240 bits, arranged as 1280 byte locations in a ring. Every line start rewinds both pointers to location 0 and throws away anything left over from the previous line. The buffer can be filled completely before the first dot enable, or it can be filled while the line drains. If the buffer is empty when a new byte is needed, the missing dots come out white (0) and a sticky underrun flag is set. A write into a full buffer is dropped and sets a sticky overrun flag. Both flags clear at the next line start.

The serialiser is a three-state machine:
- IDLE waits for a line start.
- RUN emits one bit per dot enable.
- TAIL holds the last bit for one more dot period, then drops valid.

The transitions are:
- IDLE→RUN on a start with a non-zero length.
- RUN→TAIL on the dot that emits the final bit.
- TAIL→IDLE on the next dot.
- Any state →RUN on a start with a non-zero length, or →IDLE on a start with length zero.

Top module: `rastline_fifo`

## Requirements
- R1: The buffer holds 1280 bytes. A line of 10240 bits written in full before any dot enable is played back bit-exactly, and the occupancy never exceeds 1280.
- R2: On the clock edge where `line_start` is high, the block does all of the following:
  - rewinds the read and write pointers and empties the buffer;
  - clears `underrun`, `overrun` and `video_valid`;
  - latches `line_len`;
  - discards a write presented in that same cycle.
  
  Bytes left over from an earlier line are never output.
- R3: `dma_req` is high only after a line start while the machine is not IDLE, the buffer is not full, and fewer than ceil(`line_len`/8) bytes have been accepted since that start. Otherwise it is low.
- R4: On each clock edge with `dot_en` high in RUN, `video_out` takes the next line bit. Bytes are sent most significant bit (bit 7) first, in write order.
- R5: `video_valid` is high for exactly `line_len` dot periods after a start and low otherwise. `video_out` is 0 whenever `video_valid` is low.
- R6: `video_out` and `video_valid` change only on edges where `dot_en` or `line_start` is high.
- R7: When a byte slot begins and the buffer is empty, all 8 dots of that slot are output as 0, no byte is consumed, and `underrun` is set. It stays set until the next line start.
- R8: A write while the buffer holds 1280 bytes is dropped and sets `overrun`. It stays set until the next line start.
- R9: A line start with `line_len` of 0 produces no valid dots and no DMA request.
- R10: When `line_len` is not a multiple of 8, the unused low bits of the final byte are never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that begins a raster line |
| line_len | input | 14 | Line length in bits, sampled with line_start |
| wr_data | input | 8 | Byte from the DMA engine |
| wr_en | input | 1 | Write strobe for wr_data |
| dma_req | output | 1 | Request for more line bytes |
| dot_en | input | 1 | Dot-clock enable, one pulse per video bit |
| video_out | output | 1 | Serial video bit (1 = black) |
| video_valid | output | 1 | High while a line bit is on video_out |
| underrun | output | 1 | Sticky: a byte was needed while the buffer was empty |
| overrun | output | 1 | Sticky: a byte was written into a full buffer |

## Verification
The assertions take for granted the following about the inputs:
- `line_start` is a single-cycle pulse and never coincides with a dot enable.
- `dot_en` is a strobe of one cycle or a steady train.
- The writer may keep writing after `dma_req` falls.

The stimulus follows these rules:
- It raises `line_start` on its own cycle.
- It holds `dot_en` low until the intended bytes are in place, except in the underrun and full-capacity lines.
- Overrun is provoked only deliberately, by one extra write into a full buffer.

// File: rtl/rastline_pkg.sv
package rastline_pkg;
    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_RUN  = 2'd1,
        SER_TAIL = 2'd2
    } ser_state_t;
endpackage

// File: rtl/rastline_store.sv
module rastline_store #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 1280,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              accepted,
    output logic              ovf_flag
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_wr, do_rd;

    assign full     = (level == CNT_W'(DEPTH));
    assign empty    = (level == '0);
    assign do_wr    = wr_en && !full && !clear;
    assign do_rd    = rd_en && !empty && !clear;
    assign accepted = do_wr;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_en && full) ovf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/rastline_pacer.sv
module rastline_pacer #(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LEN_W-1:0] line_len,
    input  logic             accepted,
    input  logic             full,
    input  logic             busy,
    output logic             dma_req
);
    logic [LEN_W-1:0] need, taken;
    logic [LEN_W:0]   len_round;

    assign len_round = {1'b0, line_len} + (LEN_W+1)'(BYTE_W - 1);
    assign dma_req   = busy && !full && (taken < need);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need  <= '0;
            taken <= '0;
        end else if (clear) begin
            need  <= LEN_W'(len_round / (LEN_W+1)'(BYTE_W));
            taken <= '0;
        end else if (accepted && (taken != '1)) begin
            taken <= taken + 1'b1;
        end
    end
endmodule

// File: rtl/rastline_serialiser.sv
module rastline_serialiser
    import rastline_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 14,
    localparam int BIDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  line_len,
    input  logic              dot_en,
    input  logic              empty,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic              video_out,
    output logic              video_valid,
    output logic              underrun,
    output logic              busy
);
    ser_state_t        state, nxt;
    logic [LEN_W-1:0]  bits_rem;
    logic [BIDX_W-1:0] bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              slot_start, cur_bit;

    assign slot_start = (bit_idx == '0);
    assign rd_en      = (state == SER_RUN) && dot_en && slot_start && !empty && !start;
    assign cur_bit    = slot_start ? (!empty && rd_data[BYTE_W-1]) : shreg[BYTE_W-1];
    assign busy       = (state != SER_IDLE);

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = (line_len != '0) ? SER_RUN : SER_IDLE;
        end else begin
            unique case (state)
                SER_IDLE: nxt = SER_IDLE;
                SER_RUN:  if (dot_en && bits_rem == LEN_W'(1)) nxt = SER_TAIL;
                SER_TAIL: if (dot_en) nxt = SER_IDLE;
                default:  nxt = SER_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_rem    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            video_out   <= 1'b0;
            video_valid <= 1'b0;
            underrun    <= 1'b0;
        end else if (start) begin
            bits_rem    <= line_len;
            bit_idx     <= '0;
            shreg       <= '0;
            video_out   <= 1'b0;
            video_valid <= 1'b0;
            underrun    <= 1'b0;
        end else begin
            unique case (state)
                SER_RUN: if (dot_en) begin
                    video_out   <= cur_bit;
                    video_valid <= 1'b1;
                    bits_rem    <= bits_rem - 1'b1;
                    bit_idx     <= (bit_idx == BIDX_W'(BYTE_W - 1)) ? '0 : bit_idx + 1'b1;
                    if (slot_start) begin
                        shreg <= empty ? '0 : {rd_data[BYTE_W-2:0], 1'b0};
                        if (empty) underrun <= 1'b1;
                    end else begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
                SER_TAIL: if (dot_en) begin
                    video_out   <= 1'b0;
                    video_valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rastline_fifo.sv
module rastline_fifo #(
    parameter int BYTE_W    = 8,
    parameter int LINE_BITS = 10240,
    localparam int DEPTH = LINE_BITS / BYTE_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LEN_W = $clog2(LINE_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LEN_W-1:0]  line_len,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_en,
    output logic              dma_req,
    input  logic              dot_en,
    output logic              video_out,
    output logic              video_valid,
    output logic              underrun,
    output logic              overrun
);
    logic [BYTE_W-1:0] rd_data;
    logic [CNT_W-1:0]  level;
    logic              full, empty, accepted, rd_en, busy;

    rastline_store #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(line_start),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level), .full(full), .empty(empty), .accepted(accepted),
        .ovf_flag(overrun)
    );

    rastline_pacer #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clear(line_start), .line_len(line_len),
        .accepted(accepted), .full(full), .busy(busy), .dma_req(dma_req)
    );

    rastline_serialiser #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .start(line_start), .line_len(line_len),
        .dot_en(dot_en), .empty(empty), .rd_data(rd_data), .rd_en(rd_en),
        .video_out(video_out), .video_valid(video_valid),
        .underrun(underrun), .busy(busy)
    );
endmodule

// File: rtl/rastline_fifo_checker.sv
module rastline_fifo_checker #(
    parameter int DEPTH = 1280,
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic             dot_en,
    input logic             video_out,
    input logic             video_valid,
    input logic             underrun,
    input logic             overrun,
    input logic             dma_req,
    input logic [CNT_W-1:0] level
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!video_valid && !underrun && !overrun && level == '0));

    assert_no_req_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH)) |-> !dma_req);

    assert_white_when_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !video_valid |-> !video_out);

    assert_hold_between_dots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dot_en && !line_start) |=> ($stable(video_out) && $stable(video_valid)));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !line_start) |=> underrun);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !line_start) |=> overrun);
endmodule

bind rastline_fifo rastline_fifo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .dot_en(dot_en),
    .video_out(video_out), .video_valid(video_valid), .underrun(underrun),
    .overrun(overrun), .dma_req(dma_req), .level(level)
);

// File: tb/rastline_fifo_bench.sv
module rastline_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [13:0] line_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        dot_en = 1'b0;
    logic        dma_req, video_out, video_valid, underrun, overrun;
    logic        dot_q = 1'b0;
    int          checks = 0;
    int          fails = 0;
    int          bit_no = 0;
    bit          done = 1'b0;
    bit          exp_q[$];

    always #2.5 clk = ~clk;

    rastline_fifo u_rastline_fifo (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_len(line_len),
        .wr_data(wr_data), .wr_en(wr_en), .dma_req(dma_req), .dot_en(dot_en),
        .video_out(video_out), .video_valid(video_valid),
        .underrun(underrun), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor: compare each dot against the scoreboard
    always @(posedge clk) dot_q <= dot_en;
    always @(negedge clk) begin
        if (rst_n && dot_q && video_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 extra valid dot", 1, 0);
            end else begin
                automatic bit e = exp_q.pop_front();
                check(video_out == e, $sformatf("R4 dot %0d", bit_no), video_out, e);
                bit_no++;
            end
        end
    end

    task automatic start_line(input int len);
        @(negedge clk);
        line_start = 1'b1;
        line_len = 14'(len);
        @(negedge clk);
        line_start = 1'b0;
        bit_no = 0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) exp_q.push_back(b[i]);
    endtask

    task automatic dots(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            dot_en = 1'b1;
            @(negedge clk);
            dot_en = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic end_of_line(input string tag);
        check(video_valid == 1'b0, {tag, " valid low after line"}, video_valid, 0);
        check(exp_q.size() == 0, {tag, " all bits seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(5.0 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(video_valid == 0, "reset valid", video_valid, 0);
        check(dma_req == 0, "R3 reset req", dma_req, 0);
        check(underrun == 0 && overrun == 0, "reset flags", underrun | overrun, 0);

        // R10: 20-bit line, three bytes, low 4 bits of last byte unused
        start_line(20);
        check(dma_req == 1, "R3 req after start", dma_req, 1);
        write_byte(8'hA5); expect_bits(8'hA5, 8);
        write_byte(8'h3C); expect_bits(8'h3C, 8);
        write_byte(8'h9F); expect_bits(8'h9F, 4);
        check(dma_req == 0, "R3 req drops at line bytes", dma_req, 1'b0);
        dots(21, 2);
        end_of_line("R10");
        check(underrun == 0, "R7 no underrun", underrun, 0);

        // R2: extra bytes from this line must not reach the next one
        start_line(8);
        write_byte(8'h5A); expect_bits(8'h5A, 8);
        check(dma_req == 0, "R3 one-byte line satisfied", dma_req, 0);
        write_byte(8'hFF);
        write_byte(8'hFF);
        dots(9, 1);
        end_of_line("R5");
        start_line(8);
        write_byte(8'h81); expect_bits(8'h81, 8);
        dots(9, 3);
        end_of_line("R2");

        // R7: second slot finds the buffer empty
        start_line(16);
        write_byte(8'hC3); expect_bits(8'hC3, 8); expect_bits(8'h00, 8);
        dots(17, 2);
        end_of_line("R7");
        check(underrun == 1, "R7 underrun set", underrun, 1);
        start_line(8);
        check(underrun == 0, "R2 underrun cleared", underrun, 0);
        write_byte(8'h01); expect_bits(8'h01, 8);
        dots(9, 0);
        end_of_line("R4");

        // R9: zero-length line
        start_line(0);
        check(dma_req == 0, "R9 no request", dma_req, 0);
        dots(5, 1);
        check(video_valid == 0, "R9 no valid", video_valid, 0);

        // R1/R8: full 1280-byte fill, extra write, then line longer than capacity
        start_line(16000);
        for (int i = 0; i < 1280; i++) begin
            automatic logic [7:0] b = 8'((i * 37 + 11) ^ (i >> 3));
            write_byte(b);
            expect_bits(b, 8);
        end
        check(dma_req == 0, "R3 no request when full", dma_req, 0);
        check(overrun == 0, "R8 no overrun yet", overrun, 0);
        write_byte(8'hFF);
        check(overrun == 1, "R8 overrun set", overrun, 1);
        for (int i = 0; i < 16000 - 10240; i++) exp_q.push_back(1'b0);
        dots(16001, 0);
        end_of_line("R1");
        check(overrun == 1, "R8 overrun sticky", overrun, 1);
        check(underrun == 1, "R7 past capacity", underrun, 1);
        start_line(8);
        check(overrun == 0, "R2 overrun cleared", overrun, 0);

        finish_run();
    end
endmodule